// File: doc/BRIEF.md
# Chip-Select Segment Window Decoder

This block keeps one address segment per flash chip select inside a controller's memory-mapped flash window and turns each bus access into a chip-select hit and a byte offset local to that device. Every segment is described by a start value and an end value, both counted in 8 MB units, so the size is simply end minus start. A segment whose end does not lie above its start is disabled.

Software reprograms a segment through a 32-bit write port. The write is checked against the layout rules before it is applied. The start of chip select 0 cannot move. A segment that falls outside the window is refused. A misaligned segment or one that overlaps another is reported but still takes effect. One cycle after each write, three flags report what the check found.

Accesses come in two kinds. An absolute bus address is matched against all segments, and the lowest-numbered match wins. A direct access names a chip select and gives a local offset, which is folded back into the segment when it runs past the segment's end.

Top module: `seg_window_dec`

## Requirements
- R1: After reset, chip select 0 covers 64 MB starting at the window base (unit 0x40, byte 0x2000_0000). Each following chip select covers 32 MB and starts where the previous one ends.
- R2: A write of wr_data to chip select wr_cs takes the end from bits [31:24] and the start from bits [23:16], both equal to address bits [30:23]. Bits [15:0] are ignored. The new segment is used for decoding from the clock edge that accepts the write.
- R3: A segment whose end is not greater than its start is disabled. It never produces a hit, and a direct access to it gives no hit, addr_err=1 and offset 0.
- R4: A write to chip select 0 keeps the written end but replaces the written start with the window base.
- R5: A write whose end is at or below the window base, or whose start is above the base plus the window size, is discarded. The previous segment stays in force and upd_reject is raised.
- R6: A write to an enabled segment whose start is not a multiple of its size is applied, and upd_misalign is raised.
- R7: A write whose enabled segment intersects another enabled chip select's segment is applied, and upd_overlap is raised.
- R8: With acc_direct=0, cs_hit is one-hot on the lowest-numbered chip select whose segment holds acc_addr, loc_off equals acc_addr minus the segment start, and addr_err is 0.
- R9: With acc_direct=0, an address that no segment holds gives cs_hit=0 and addr_err=1.
- R10: With acc_direct=1, cs_hit selects acc_cs and loc_off is acc_addr modulo the segment size. addr_err is 1 exactly when acc_addr is at least the size.
- R11: The update flags are valid for the single cycle after an accepted write and read 0 at all other times. A rejected write raises neither upd_misalign nor upd_overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Segment write strobe |
| wr_cs | input | CS_W | Chip select whose segment is written |
| wr_data | input | 32 | Segment value: end [31:24], start [23:16] |
| acc_direct | input | 1 | 1: direct access to acc_cs, 0: decode acc_addr |
| acc_cs | input | CS_W | Target chip select for a direct access |
| acc_addr | input | ADDR_W | Absolute bus address, or local offset when direct |
| cs_hit | output | NUM_CS | One-hot chip-select hit |
| loc_off | output | ADDR_W | Byte offset inside the hit segment |
| addr_err | output | 1 | Unmapped address or wrapped offset |
| upd_reject | output | 1 | Last write discarded |
| upd_misalign | output | 1 | Last write misaligned |
| upd_overlap | output | 1 | Last write overlaps another segment |

## Verification
The bench builds the block with its default parameters: five chip selects, a 31-bit address, a window base at unit 0x40 and a window 32 units (256 MB) wide. With these values both window limits can be reached by 8-bit field values, so the rejection edges can be driven. Five segments also leave room to stack two of them on one range, which exercises the overlap flag and the lowest-number priority. Because the default segment sizes are powers of two, an offset in unit 5 on a 4-unit segment gives a clean wrap case, and placing a start at 0x4A gives a clean misalignment case.

// File: rtl/seg_pkg.sv
package seg_pkg;
   localparam int UNIT_W = 8;
   localparam int REG_W  = 32;

   typedef struct packed {
      logic [UNIT_W-1:0] s_end;
      logic [UNIT_W-1:0] s_start;
   } seg_t;

   // Reset layout: first chip select is wider, the rest follow back to back
   function automatic logic [UNIT_W-1:0] def_start(int idx, int base, int first, int rest);
      return (idx == 0) ? UNIT_W'(base) : UNIT_W'(base + first + (idx - 1) * rest);
   endfunction

   function automatic logic [UNIT_W-1:0] def_end(int idx, int base, int first, int rest);
      return (idx == 0) ? UNIT_W'(base + first) : UNIT_W'(base + first + idx * rest);
   endfunction
endpackage

// File: rtl/seg_upd_check.sv
module seg_upd_check
   import seg_pkg::*;
#(
   parameter int NUM_CS     = 5,
   parameter int CS_W       = 3,
   parameter int WIN_BASE_U = 64,
   parameter int WIN_UNITS  = 32
) (
   input  logic [CS_W-1:0]        wr_cs,
   input  logic [15:0]            fld,
   input  seg_t [NUM_CS-1:0]      segs,
   output seg_t                   nseg,
   output logic                   reject,
   output logic                   misalign,
   output logic                   overlap
);
   localparam logic [UNIT_W-1:0] BASE_U = UNIT_W'(WIN_BASE_U);
   localparam logic [UNIT_W:0]   BASE9  = (UNIT_W+1)'(WIN_BASE_U);
   localparam logic [UNIT_W:0]   TOP9   = (UNIT_W+1)'(WIN_BASE_U + WIN_UNITS);

   logic [UNIT_W-1:0] ns, ne, nsize, divisor;
   logic              nen;
   logic [NUM_CS-1:0] ov;

   always_comb begin
      ne      = fld[15:8];
      ns      = (wr_cs == '0) ? BASE_U : fld[7:0];
      nen     = ne > ns;
      nsize   = ne - ns;
      divisor = nen ? nsize : UNIT_W'(1);
      reject  = ({1'b0, ne} <= BASE9) || ({1'b0, ns} > TOP9);
      misalign = !reject && nen && ((ns % divisor) != '0);
      nseg.s_end   = ne;
      nseg.s_start = ns;
   end

   for (genvar j = 0; j < NUM_CS; j++) begin : g_ov
      assign ov[j] = nen && (wr_cs != CS_W'(j)) &&
                     (segs[j].s_end > segs[j].s_start) &&
                     (ne > segs[j].s_start) && (ns < segs[j].s_end);
   end

   assign overlap = !reject && (|ov);
endmodule

// File: rtl/seg_bank.sv
module seg_bank
   import seg_pkg::*;
#(
   parameter int NUM_CS     = 5,
   parameter int CS_W       = 3,
   parameter int WIN_BASE_U = 64,
   parameter int WIN_UNITS  = 32,
   parameter int CS0_UNITS  = 8,
   parameter int CSN_UNITS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CS_W-1:0]   wr_cs,
   input  logic [15:0]       fld,
   output seg_t [NUM_CS-1:0] segs,
   output logic              upd_reject,
   output logic              upd_misalign,
   output logic              upd_overlap
);
   localparam logic [CS_W:0] NCS = (CS_W+1)'(NUM_CS);

   seg_t nseg;
   logic rej, mis, ovl, wr_ok;

   seg_upd_check #(
      .NUM_CS(NUM_CS), .CS_W(CS_W), .WIN_BASE_U(WIN_BASE_U), .WIN_UNITS(WIN_UNITS)
   ) u_chk (
      .wr_cs(wr_cs), .fld(fld), .segs(segs),
      .nseg(nseg), .reject(rej), .misalign(mis), .overlap(ovl)
   );

   assign wr_ok = wr_en && ({1'b0, wr_cs} < NCS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CS; i++) begin
            segs[i].s_start <= def_start(i, WIN_BASE_U, CS0_UNITS, CSN_UNITS);
            segs[i].s_end   <= def_end(i, WIN_BASE_U, CS0_UNITS, CSN_UNITS);
         end
         upd_reject   <= 1'b0;
         upd_misalign <= 1'b0;
         upd_overlap  <= 1'b0;
      end else begin
         upd_reject   <= wr_ok && rej;
         upd_misalign <= wr_ok && mis;
         upd_overlap  <= wr_ok && ovl;
         if (wr_ok && !rej) begin
            segs[wr_cs] <= nseg;
         end
      end
   end
endmodule

// File: rtl/seg_decode.sv
module seg_decode
   import seg_pkg::*;
#(
   parameter int NUM_CS  = 5,
   parameter int CS_W    = 3,
   parameter int ADDR_W  = 31,
   parameter int UNIT_SH = 23
) (
   input  seg_t [NUM_CS-1:0]  segs,
   input  logic               acc_direct,
   input  logic [CS_W-1:0]    acc_cs,
   input  logic [ADDR_W-1:0]  acc_addr,
   output logic [NUM_CS-1:0]  cs_hit,
   output logic [ADDR_W-1:0]  loc_off,
   output logic               addr_err
);
   localparam logic [CS_W:0] NCS = (CS_W+1)'(NUM_CS);

   logic [UNIT_W-1:0] addr_u;
   logic [NUM_CS-1:0] en, match;

   assign addr_u = acc_addr[ADDR_W-1:UNIT_SH];

   for (genvar i = 0; i < NUM_CS; i++) begin : g_match
      assign en[i]    = segs[i].s_end > segs[i].s_start;
      assign match[i] = en[i] && (addr_u >= segs[i].s_start) && (addr_u < segs[i].s_end);
   end

   logic [CS_W-1:0]   sel;
   logic              found;
   logic [UNIT_W-1:0] dsize;

   always_comb begin
      cs_hit   = '0;
      loc_off  = '0;
      addr_err = 1'b1;
      sel      = '0;
      found    = 1'b0;
      dsize    = '0;
      if (acc_direct) begin
         if (({1'b0, acc_cs} < NCS) && en[acc_cs]) begin
            dsize          = segs[acc_cs].s_end - segs[acc_cs].s_start;
            cs_hit[acc_cs] = 1'b1;
            addr_err       = addr_u >= dsize;
            loc_off        = {addr_u % dsize, acc_addr[UNIT_SH-1:0]};
         end
      end else begin
         for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (match[i]) begin
               sel   = CS_W'(i);
               found = 1'b1;
            end
         end
         if (found) begin
            cs_hit[sel] = 1'b1;
            loc_off     = acc_addr - {segs[sel].s_start, {UNIT_SH{1'b0}}};
            addr_err    = 1'b0;
         end
      end
   end
endmodule

// File: rtl/seg_window_dec.sv
module seg_window_dec
   import seg_pkg::*;
#(
   parameter int NUM_CS     = 5,
   parameter int ADDR_W     = 31,
   parameter int UNIT_SH    = 23,
   parameter int WIN_BASE_U = 64,
   parameter int WIN_UNITS  = 32,
   parameter int CS0_UNITS  = 8,
   parameter int CSN_UNITS  = 4,
   localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CS_W-1:0]   wr_cs,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              acc_direct,
   input  logic [CS_W-1:0]   acc_cs,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic [NUM_CS-1:0] cs_hit,
   output logic [ADDR_W-1:0] loc_off,
   output logic              addr_err,
   output logic              upd_reject,
   output logic              upd_misalign,
   output logic              upd_overlap
);
   if (NUM_CS < 1 || NUM_CS > 8) begin : g_bad_cs
      $error("seg_window_dec: NUM_CS must lie in 1..8");
   end
   if (ADDR_W - UNIT_SH != UNIT_W) begin : g_bad_unit
      $error("seg_window_dec: address field must be exactly UNIT_W bits");
   end
   if (WIN_BASE_U + WIN_UNITS > 255) begin : g_bad_win
      $error("seg_window_dec: window exceeds the unit field");
   end
   if (CS0_UNITS + (NUM_CS - 1) * CSN_UNITS > WIN_UNITS) begin : g_bad_def
      $error("seg_window_dec: reset layout does not fit the window");
   end

   wire unused_lo = ^wr_data[15:0];

   seg_t [NUM_CS-1:0] segs;

   seg_bank #(
      .NUM_CS(NUM_CS), .CS_W(CS_W), .WIN_BASE_U(WIN_BASE_U), .WIN_UNITS(WIN_UNITS),
      .CS0_UNITS(CS0_UNITS), .CSN_UNITS(CSN_UNITS)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cs(wr_cs), .fld(wr_data[31:16]),
      .segs(segs), .upd_reject(upd_reject), .upd_misalign(upd_misalign),
      .upd_overlap(upd_overlap)
   );

   seg_decode #(
      .NUM_CS(NUM_CS), .CS_W(CS_W), .ADDR_W(ADDR_W), .UNIT_SH(UNIT_SH)
   ) u_dec (
      .segs(segs), .acc_direct(acc_direct), .acc_cs(acc_cs), .acc_addr(acc_addr),
      .cs_hit(cs_hit), .loc_off(loc_off), .addr_err(addr_err)
   );
endmodule

// File: rtl/seg_window_chk.sv
module seg_window_chk #(
   parameter int NUM_CS = 5,
   parameter int CS_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              acc_direct,
   input logic [CS_W-1:0]   acc_cs,
   input logic [NUM_CS-1:0] cs_hit,
   input logic              addr_err,
   input logic              upd_reject,
   input logic              upd_misalign,
   input logic              upd_overlap
);
   // R8
   hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_hit));

   // R8
   hit_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_direct && cs_hit != '0) |-> !addr_err);

   // R9
   unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_direct && cs_hit == '0) |-> addr_err);

   // R10
   direct_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_direct && cs_hit != '0) |-> (cs_hit == (NUM_CS'(1) << acc_cs)));

   // R11
   reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_reject |-> !(upd_misalign || upd_overlap));

   // R11
   flag_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_reject || upd_misalign || upd_overlap) |-> $past(wr_en));
endmodule

bind seg_window_dec seg_window_chk #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_direct(acc_direct), .acc_cs(acc_cs),
   .cs_hit(cs_hit), .addr_err(addr_err), .upd_reject(upd_reject),
   .upd_misalign(upd_misalign), .upd_overlap(upd_overlap)
);

// File: tb/sim_seg_window_dec.sv
`timescale 1ns/100ps
module sim_seg_window_dec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_cs = '0;
   logic [31:0] wr_data = '0;
   logic        acc_direct = 1'b0;
   logic [2:0]  acc_cs = '0;
   logic [30:0] acc_addr = '0;
   logic [4:0]  cs_hit;
   logic [30:0] loc_off;
   logic        addr_err, upd_reject, upd_misalign, upd_overlap;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   seg_window_dec u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cs(wr_cs), .wr_data(wr_data),
      .acc_direct(acc_direct), .acc_cs(acc_cs), .acc_addr(acc_addr),
      .cs_hit(cs_hit), .loc_off(loc_off), .addr_err(addr_err),
      .upd_reject(upd_reject), .upd_misalign(upd_misalign), .upd_overlap(upd_overlap)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic probe(input string tag, input logic dir, input logic [2:0] cs,
                        input logic [30:0] addr, input logic [4:0] e_hit,
                        input logic [30:0] e_off, input logic e_err);
      @(negedge clk);
      acc_direct = dir; acc_cs = cs; acc_addr = addr;
      #1;
      check({tag, " hit"}, 64'(cs_hit), 64'(e_hit));
      check({tag, " off"}, 64'(loc_off), 64'(e_off));
      check({tag, " err"}, 64'(addr_err), 64'(e_err));
   endtask

   // Write one segment, then check the flags of that write and their clearing
   task automatic seg_write(input string tag, input logic [2:0] cs, input logic [7:0] e_end,
                            input logic [7:0] e_start, input logic e_rej,
                            input logic e_mis, input logic e_ovl);
      @(negedge clk);
      wr_en = 1'b1; wr_cs = cs; wr_data = {e_end, e_start, 16'hA5C3};
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      check({tag, " reject"}, 64'(upd_reject), 64'(e_rej));
      check({tag, " misalign"}, 64'(upd_misalign), 64'(e_mis));
      check({tag, " overlap"}, 64'(upd_overlap), 64'(e_ovl));
      @(posedge clk);
      #1;
      check({tag, " R11 flags clear"}, 64'({upd_reject, upd_misalign, upd_overlap}), 64'(0));
   endtask

   task automatic t_reset;
      check("R11 reset flags", 64'({upd_reject, upd_misalign, upd_overlap}), 64'(0));
      probe("R1 cs0 base", 1'b0, 3'd0, 31'h2000_0000, 5'b00001, 31'h0, 1'b0);
      probe("R1 cs0 mid", 1'b0, 3'd0, 31'h2100_0000, 5'b00001, 31'h0100_0000, 1'b0);
      probe("R1 cs1", 1'b0, 3'd0, 31'h2400_0010, 5'b00010, 31'h10, 1'b0);
      probe("R1 cs4", 1'b0, 3'd0, 31'h2A00_0004, 5'b10000, 31'h4, 1'b0);
      probe("R9 past layout", 1'b0, 3'd0, 31'h2C00_0000, 5'b00000, 31'h0, 1'b1);
   endtask

   task automatic t_format;
      seg_write("R2 cs2 move", 3'd2, 8'h5C, 8'h58, 1'b0, 1'b0, 1'b0);
      probe("R2 cs2 new", 1'b0, 3'd0, 31'h2C00_0020, 5'b00100, 31'h20, 1'b0);
      probe("R9 cs2 old", 1'b0, 3'd0, 31'h2600_0000, 5'b00000, 31'h0, 1'b1);
   endtask

   task automatic t_disabled;
      seg_write("R3 cs3 empty", 3'd3, 8'h50, 8'h50, 1'b0, 1'b0, 1'b0);
      probe("R3 no hit", 1'b0, 3'd0, 31'h2800_0000, 5'b00000, 31'h0, 1'b1);
      probe("R3 direct", 1'b1, 3'd3, 31'h0000_0100, 5'b00000, 31'h0, 1'b1);
   endtask

   task automatic t_cs0_lock;
      seg_write("R4 cs0 start", 3'd0, 8'h44, 8'h10, 1'b0, 1'b0, 1'b0);
      probe("R4 base kept", 1'b0, 3'd0, 31'h2000_0000, 5'b00001, 31'h0, 1'b0);
      probe("R4 low start", 1'b0, 3'd0, 31'h0800_0000, 5'b00000, 31'h0, 1'b1);
      probe("R4 end taken", 1'b0, 3'd0, 31'h2200_0000, 5'b00000, 31'h0, 1'b1);
   endtask

   task automatic t_reject;
      seg_write("R5 end at base", 3'd1, 8'h40, 8'h30, 1'b1, 1'b0, 1'b0);
      probe("R5 cs1 kept a", 1'b0, 3'd0, 31'h2400_0000, 5'b00010, 31'h0, 1'b0);
      seg_write("R5 start high", 3'd1, 8'h70, 8'h61, 1'b1, 1'b0, 1'b0);
      probe("R5 cs1 kept b", 1'b0, 3'd0, 31'h2580_0000, 5'b00010, 31'h0180_0000, 1'b0);
   endtask

   task automatic t_misalign;
      seg_write("R6 cs1 odd", 3'd1, 8'h4E, 8'h4A, 1'b0, 1'b1, 1'b0);
      probe("R6 applied", 1'b0, 3'd0, 31'h2500_0000, 5'b00010, 31'h0, 1'b0);
   endtask

   task automatic t_overlap;
      seg_write("R7 cs4 on cs2", 3'd4, 8'h5C, 8'h58, 1'b0, 1'b0, 1'b1);
      probe("R8 lowest wins", 1'b0, 3'd0, 31'h2C00_0000, 5'b00100, 31'h0, 1'b0);
      probe("R7 applied", 1'b0, 3'd0, 31'h2B00_0000, 5'b00000, 31'h0, 1'b1);
   endtask

   task automatic t_direct;
      probe("R10 in range", 1'b1, 3'd1, 31'h0100_0040, 5'b00010, 31'h0100_0040, 1'b0);
      probe("R10 wrap", 1'b1, 3'd1, 31'h0280_0000, 5'b00010, 31'h0080_0000, 1'b1);
      probe("R10 edge", 1'b1, 3'd1, 31'h0200_0000, 5'b00010, 31'h0, 1'b1);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_format;
      t_disabled;
      t_cs0_lock;
      t_reject;
      t_misalign;
      t_overlap;
      t_direct;
      finish_run;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run;
      end
   end
endmodule